// File: doc/BRIEF.md
# Serial LED Shift Controller

This peripheral drives a daisy chain of external 8-bit serial-in, parallel-out registers, such as the ones behind a panel of status LEDs. A CPU writes an output word into a register and then either requests a one-shot update or leaves a timer to refresh the chain at a fixed rate. Each update, called a frame, captures the word, shifts it out most significant bit first on a serial data line with its own shift clock, and ends with a one-cycle store pulse so that all external outputs change together.

A few low-order positions of the word can be handed to hardware status sources instead of the CPU: a two-bit modem status pair and two two-bit PHY status fields. Each override is enabled bit by bit through control fields. Up to three 8-bit groups can be enabled, and the frame length follows the highest enabled group. The shift-clock edge on which the serial data changes is programmable.

The register interface is a simple 32-bit word-addressed port with a combinational read path. The same clock drives the bus, the refresh timer and the serialiser.

Top module: `led_shift_ctrl`

## Requirements
- R1: After reset, control 0 reads 0x8000_0000 and every other register reads 0. The shift clock, serial data and store outputs stay low, and no frame starts until an update is requested.
- R2: Registers sit at byte offsets 0x00 (control 0), 0x04 (control 1), 0x08 (data), 0x0C (spare data) and 0x10 (access). Each reads back what was written, except bit 0 of the access register, which reads the busy flag.
- R3: A write to control 0 with bit 31 set starts exactly one frame. A write with bit 31 clear starts none.
- R4: Bits [2:0] of control 1 enable groups 0 to 2. A frame shifts 8×(index of highest enabled group + 1) bits. When no group is enabled, no frame starts.
- R5: A frame shifts bits from the highest position down to bit 0, one bit per shift-clock period.
- R6: Output bit k (k=0,1) takes modem_stat[k] when control 0 bit 24+k is set. Bit 2+k takes phy1_stat[k] when control 0 bit 27+k is set. Bit 5+k takes phy2_stat[k] when control 1 bit 15+k is set. Every other bit takes the data register bit.
- R7: When control 0 bit 26 is set, serial data changes on falling shift-clock edges and the clock is low in the first half of each bit. When the bit is clear, data changes on rising edges and the clock is high in the first half. The clock idles low in both modes.
- R8: Each bit lasts 2×HALF_DIV clock cycles. A single-cycle store pulse follows the last bit. Busy (access bit 0) is high from the first bit through the store cycle, so a frame occupies nbits×2×HALF_DIV+1 cycles.
- R9: An update request that arrives during a frame is held. One further frame then starts on the cycle after the store pulse, so consecutive store pulses are nbits×2×HALF_DIV+1 cycles apart.
- R10: When control 0 bit 31 is clear and control 1 bit 31 is set, frames repeat every CLK_HZ/f cycles, with f chosen by control 1 bits [24:23] (0: 2, 1: 4, 2: 8, 3: 10). With control 1 bit 31 clear, no timed frames occur.
- R11: The merged word is captured when the frame starts. Later writes to the data register, or status changes, do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus, timer and serialiser |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| modem_stat | input | 2 | Modem status bits for output positions 0 and 1 |
| phy1_stat | input | 2 | First PHY status bits for positions 2 and 3 |
| phy2_stat | input | 2 | Second PHY status bits for positions 5 and 6 |
| sr_clk | output | 1 | Shift clock to the external chain |
| sr_data | output | 1 | Serial data to the external chain |
| sr_store | output | 1 | One-cycle store pulse after the last bit |

## Verification
The edge-ordering properties assume that the programmed edge mode and the shifted word change only at the start of a frame. The stimulus therefore changes control 0 only between frames, or through a write that itself starts the frame. The launch and idle properties assume that bus writes last exactly one cycle and that the group field is stable while a request is being decided. The bench holds each write strobe for a single cycle and returns the address to the access register afterwards, so the busy flag can be observed without gaps.

// File: rtl/lsc_pkg.sv
// Package: shared register offsets, field positions, state and config types
// for the serial LED shift controller. Assumes a 32-bit register port.
package lsc_pkg;

    localparam int CSR_AW = 5;

    localparam logic [CSR_AW-1:0] CSR_CTRL0  = 5'h00;
    localparam logic [CSR_AW-1:0] CSR_CTRL1  = 5'h04;
    localparam logic [CSR_AW-1:0] CSR_DATA0  = 5'h08;
    localparam logic [CSR_AW-1:0] CSR_DATA1  = 5'h0C;
    localparam logic [CSR_AW-1:0] CSR_ACCESS = 5'h10;

    // control 0 field positions
    localparam int C0_SW_MODE   = 31;
    localparam int C0_FALL_EDGE = 26;
    localparam int C0_MODEM_LSB = 24;
    localparam int C0_PHY1_LSB  = 27;

    // control 1 field positions
    localparam int C1_GROUP_LSB = 0;
    localparam int C1_PHY2_LSB  = 15;
    localparam int C1_RATE_LSB  = 23;
    localparam int C1_BUS_SRC   = 31;

    // output word positions taken over by hardware sources
    localparam int OUT_MODEM_LSB = 0;
    localparam int OUT_PHY1_LSB  = 2;
    localparam int OUT_PHY2_LSB  = 5;
    localparam int OVR_W         = 2;
    localparam int GRP_FIELD_W   = 3;

    localparam logic [31:0] CTRL0_RESET = 32'h8000_0000;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_SHIFT = 2'd1,
        SER_STORE = 2'd2
    } ser_state_e;

    typedef struct packed {
        logic                   sw_mode;
        logic                   fall_edge;
        logic [OVR_W-1:0]       modem_ovr;
        logic [OVR_W-1:0]       phy1_ovr;
        logic [OVR_W-1:0]       phy2_ovr;
        logic [GRP_FIELD_W-1:0] groups;
        logic [1:0]             rate;
        logic                   bus_src;
    } lsc_cfg_t;

endpackage

// File: rtl/lsc_regs.sv
// Module: register file. Holds the two control words, the data words and the
// access word, decodes writes, and raises a one-cycle software update request
// when control 0 is written with its mode bit set. Assumes single-cycle
// write strobes; reads are combinational on the address.
module lsc_regs
    import lsc_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [CSR_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    output lsc_cfg_t          cfg,
    output logic [WORD_W-1:0] cpu_word,
    output logic              sw_req
);

    logic [31:0] ctrl0_q;
    logic [31:0] ctrl1_q;
    logic [31:0] data0_q;
    logic [31:0] data1_q;
    logic [31:1] access_q;
    logic        wr_en;

    assign wr_en = bus_sel && bus_wr;

    // register storage, written by the bus port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl0_q  <= CTRL0_RESET;
            ctrl1_q  <= '0;
            data0_q  <= '0;
            data1_q  <= '0;
            access_q <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                CSR_CTRL0:  ctrl0_q  <= bus_wdata;
                CSR_CTRL1:  ctrl1_q  <= bus_wdata;
                CSR_DATA0:  data0_q  <= bus_wdata;
                CSR_DATA1:  data1_q  <= bus_wdata;
                CSR_ACCESS: access_q <= bus_wdata[31:1];
                default:    ;
            endcase
        end
    end

    // one-shot update request from a control 0 write with the mode bit set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_req <= 1'b0;
        end else begin
            sw_req <= wr_en && (bus_addr == CSR_CTRL0) && bus_wdata[C0_SW_MODE];
        end
    end

    // read multiplexer, busy flag in access bit 0
    always_comb begin
        case (bus_addr)
            CSR_CTRL0:  bus_rdata = ctrl0_q;
            CSR_CTRL1:  bus_rdata = ctrl1_q;
            CSR_DATA0:  bus_rdata = data0_q;
            CSR_DATA1:  bus_rdata = data1_q;
            CSR_ACCESS: bus_rdata = {access_q, busy};
            default:    bus_rdata = '0;
        endcase
    end

    // configuration fields handed to the datapath
    always_comb begin
        cfg.sw_mode   = ctrl0_q[C0_SW_MODE];
        cfg.fall_edge = ctrl0_q[C0_FALL_EDGE];
        cfg.modem_ovr = ctrl0_q[C0_MODEM_LSB +: OVR_W];
        cfg.phy1_ovr  = ctrl0_q[C0_PHY1_LSB +: OVR_W];
        cfg.phy2_ovr  = ctrl1_q[C1_PHY2_LSB +: OVR_W];
        cfg.groups    = ctrl1_q[C1_GROUP_LSB +: GRP_FIELD_W];
        cfg.rate      = ctrl1_q[C1_RATE_LSB +: 2];
        cfg.bus_src   = ctrl1_q[C1_BUS_SRC];
    end

    assign cpu_word = data0_q[WORD_W-1:0];

endmodule

// File: rtl/lsc_refresh_timer.sv
// Module: refresh timer. While enabled, emits a one-cycle tick every
// CLK_HZ/f cycles, with f selected by a 2-bit rate code (2, 4, 8, 10).
// Assumes CLK_HZ is at least 10. The count restarts when disabled.
module lsc_refresh_timer #(
    parameter int CLK_HZ = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] rate,
    output logic       tick
);

    localparam int PER_2  = CLK_HZ / 2;
    localparam int PER_4  = CLK_HZ / 4;
    localparam int PER_8  = CLK_HZ / 8;
    localparam int PER_10 = CLK_HZ / 10;
    localparam int CNT_W  = $clog2(PER_2 + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             wrap;

    // terminal count for the selected rate
    always_comb begin
        case (rate)
            2'd0:    last_cnt = CNT_W'(PER_2 - 1);
            2'd1:    last_cnt = CNT_W'(PER_4 - 1);
            2'd2:    last_cnt = CNT_W'(PER_8 - 1);
            default: last_cnt = CNT_W'(PER_10 - 1);
        endcase
    end

    assign wrap = (cnt_q >= last_cnt);

    // period counter and tick register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (!enable) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            tick  <= wrap;
        end
    end

endmodule

// File: rtl/lsc_merge.sv
// Module: output word merge. Each position covered by an enabled override
// takes its hardware status bit; all other positions take the CPU word.
// Purely combinational; assumes WORD_W covers the highest override bit.
module lsc_merge
    import lsc_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic [WORD_W-1:0] cpu_word,
    input  logic [OVR_W-1:0]  modem_stat,
    input  logic [OVR_W-1:0]  phy1_stat,
    input  logic [OVR_W-1:0]  phy2_stat,
    input  logic [OVR_W-1:0]  modem_ovr,
    input  logic [OVR_W-1:0]  phy1_ovr,
    input  logic [OVR_W-1:0]  phy2_ovr,
    output logic [WORD_W-1:0] merged
);

    logic [WORD_W-1:0] hw_vec;
    logic [WORD_W-1:0] hw_mask;

    // place status bits and their enables at their output positions
    always_comb begin
        hw_vec  = '0;
        hw_mask = '0;
        for (int k = 0; k < OVR_W; k++) begin
            hw_vec [OUT_MODEM_LSB + k] = modem_stat[k];
            hw_mask[OUT_MODEM_LSB + k] = modem_ovr[k];
            hw_vec [OUT_PHY1_LSB + k]  = phy1_stat[k];
            hw_mask[OUT_PHY1_LSB + k]  = phy1_ovr[k];
            hw_vec [OUT_PHY2_LSB + k]  = phy2_stat[k];
            hw_mask[OUT_PHY2_LSB + k]  = phy2_ovr[k];
        end
    end

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign merged[i] = hw_mask[i] ? hw_vec[i] : cpu_word[i];
    end

endmodule

// File: rtl/lsc_serializer.sv
// Module: frame serialiser. On a request it captures the word and edge mode,
// shifts 8 x (highest enabled group + 1) bits MSB first at 2*HALF_DIV cycles
// per bit, then pulses store for one cycle. A request during a frame is held
// and launches the next frame directly from the store cycle.
module lsc_serializer
    import lsc_pkg::*;
#(
    parameter int WORD_W     = 24,
    parameter int NUM_GROUPS = 3,
    parameter int HALF_DIV   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [NUM_GROUPS-1:0] groups,
    input  logic                  fall_edge,
    input  logic [WORD_W-1:0]     word,
    output logic                  sr_clk,
    output logic                  sr_data,
    output logic                  sr_store,
    output logic                  busy,
    output logic                  frame_fall
);

    localparam int IDX_W = $clog2(WORD_W);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    ser_state_e        state_q;
    logic [WORD_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DIV_W-1:0]  div_q;
    logic              half_q;
    logic              fall_q;
    logic              pend_q;
    logic [IDX_W:0]    nbits;
    logic              launch;
    logic              div_end;

    // frame length from the highest enabled group
    always_comb begin
        nbits = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (groups[g]) nbits = (IDX_W + 1)'(8 * (g + 1));
        end
    end

    assign launch  = (nbits != '0) &&
                     (((state_q == SER_IDLE) && start) ||
                      ((state_q == SER_STORE) && (start || pend_q)));
    assign div_end = (div_q == DIV_W'(HALF_DIV - 1));

    // frame sequencer: capture, bit timing, store and pending request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SER_IDLE;
            shreg_q <= '0;
            idx_q   <= '0;
            div_q   <= '0;
            half_q  <= 1'b0;
            fall_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else if (launch) begin
            state_q <= SER_SHIFT;
            shreg_q <= word;
            idx_q   <= IDX_W'(nbits - 1'b1);
            div_q   <= '0;
            half_q  <= 1'b0;
            fall_q  <= fall_edge;
            pend_q  <= 1'b0;
        end else begin
            case (state_q)
                SER_SHIFT: begin
                    if (start) pend_q <= 1'b1;
                    if (div_end) begin
                        div_q <= '0;
                        if (half_q) begin
                            half_q <= 1'b0;
                            if (idx_q == '0) state_q <= SER_STORE;
                            else             idx_q   <= idx_q - 1'b1;
                        end else begin
                            half_q <= 1'b1;
                        end
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                SER_STORE: begin
                    state_q <= SER_IDLE;
                    pend_q  <= 1'b0;
                end
                default: pend_q <= 1'b0;
            endcase
        end
    end

    // pin outputs decoded from the sequencer state
    always_comb begin
        sr_data  = (state_q == SER_SHIFT) && shreg_q[idx_q];
        sr_clk   = (state_q == SER_SHIFT) && (fall_q ? half_q : !half_q);
        sr_store = (state_q == SER_STORE);
        busy     = (state_q != SER_IDLE);
    end

    assign frame_fall = fall_q;

endmodule

// File: rtl/led_shift_ctrl.sv
// Module: top of the serial LED shift controller. Ties the register file,
// refresh timer, override merge and serialiser together. A frame request is
// the software update pulse or, in timed mode with the bus clock selected,
// the timer tick.
module led_shift_ctrl
    import lsc_pkg::*;
#(
    parameter int NUM_GROUPS = 3,
    parameter int HALF_DIV   = 2,
    parameter int CLK_HZ     = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [CSR_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [1:0]        modem_stat,
    input  logic [1:0]        phy1_stat,
    input  logic [1:0]        phy2_stat,
    output logic              sr_clk,
    output logic              sr_data,
    output logic              sr_store
);

    localparam int WORD_W = 8 * NUM_GROUPS;

    lsc_cfg_t                  cfg;
    logic [WORD_W-1:0]         cpu_word;
    logic [WORD_W-1:0]         merged;
    logic                      sw_req;
    logic                      tick;
    logic                      timer_en;
    logic                      frame_req;
    logic                      ser_busy;
    logic                      ser_fall;
    logic [GRP_FIELD_W-1:0]    grp_en;

    assign timer_en  = !cfg.sw_mode && cfg.bus_src;
    assign frame_req = sw_req || tick;
    assign grp_en    = cfg.groups;

    lsc_regs #(.WORD_W(WORD_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (ser_busy),
        .cfg       (cfg),
        .cpu_word  (cpu_word),
        .sw_req    (sw_req)
    );

    lsc_refresh_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (timer_en),
        .rate   (cfg.rate),
        .tick   (tick)
    );

    lsc_merge #(.WORD_W(WORD_W)) u_merge (
        .cpu_word   (cpu_word),
        .modem_stat (modem_stat),
        .phy1_stat  (phy1_stat),
        .phy2_stat  (phy2_stat),
        .modem_ovr  (cfg.modem_ovr),
        .phy1_ovr   (cfg.phy1_ovr),
        .phy2_ovr   (cfg.phy2_ovr),
        .merged     (merged)
    );

    lsc_serializer #(
        .WORD_W     (WORD_W),
        .NUM_GROUPS (NUM_GROUPS),
        .HALF_DIV   (HALF_DIV)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (frame_req),
        .groups     (grp_en[NUM_GROUPS-1:0]),
        .fall_edge  (cfg.fall_edge),
        .word       (merged),
        .sr_clk     (sr_clk),
        .sr_data    (sr_data),
        .sr_store   (sr_store),
        .busy       (ser_busy),
        .frame_fall (ser_fall)
    );

endmodule

// File: rtl/lsc_checker.sv
// Module: property checker for the serial LED shift controller, bound to
// the top. Assumes the edge mode only changes when a frame launches.
module lsc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sr_clk,
    input logic       sr_data,
    input logic       sr_store,
    input logic       busy,
    input logic       frame_fall,
    input logic       frame_req,
    input logic [2:0] groups
);

    AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sr_clk && !sr_data && !sr_store)); // R1

    AST_REQ_LAUNCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_req && !busy && (groups != 3'b000)) |=> (busy && !sr_store)); // R3

    AST_NO_GROUP_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (groups == 3'b000)) |=> !busy); // R4

    AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_store |=> !sr_store); // R8

    AST_STORE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sr_store |-> busy); // R8

    AST_FALL_MODE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !sr_store && !$past(sr_store) && frame_fall &&
         $stable(frame_fall) && (sr_data != $past(sr_data))) |-> $fell(sr_clk)); // R7

    AST_RISE_MODE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !sr_store && !$past(sr_store) && !frame_fall &&
         $stable(frame_fall) && (sr_data != $past(sr_data))) |-> $rose(sr_clk)); // R7

endmodule

bind led_shift_ctrl lsc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sr_clk     (sr_clk),
    .sr_data    (sr_data),
    .sr_store   (sr_store),
    .busy       (ser_busy),
    .frame_fall (ser_fall),
    .frame_req  (frame_req),
    .groups     (grp_en)
);

// File: tb/led_shift_ctrl_test.sv
// Bench: sweeps group sets, edge modes, all override combinations, pending
// requests and every refresh rate, decoding the serial pins independently.
module led_shift_ctrl_test;
    import lsc_pkg::*;

    localparam int CLK_HZ  = 2000;
    localparam int HALF    = 2;
    localparam int BIT_CYC = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = CSR_ACCESS;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  modem_stat = '0;
    logic [1:0]  phy1_stat = '0;
    logic [1:0]  phy2_stat = '0;
    logic        sr_clk, sr_data, sr_store;

    always #2 clk = ~clk;

    led_shift_ctrl #(.NUM_GROUPS(3), .HALF_DIV(HALF), .CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .modem_stat(modem_stat), .phy1_stat(phy1_stat), .phy2_stat(phy2_stat),
        .sr_clk(sr_clk), .sr_data(sr_data), .sr_store(sr_store)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    longint cyc = 0;

    // pin decoder state
    logic [23:0] cap_word = '0;
    int          cap_n = 0;
    int          frames = 0;
    logic [23:0] last_word = '0;
    int          last_n = 0;
    int          last_len = 0;
    int          busy_cnt = 0;
    longint      last_store_cyc = 0;
    int          last_interval = 0;
    int          edge_err = 0;
    int          idle_err = 0;
    bit          idle_watch = 0;
    bit          exp_fall = 0;
    logic        prev_clk = 0;
    logic        prev_data = 0;

    // decode the serial pins away from the active edge
    always @(negedge clk) begin
        bit cap_edge;
        bit bz;
        cyc++;
        if (rst_n) begin
            cap_edge = exp_fall ? (!prev_clk && sr_clk) : (prev_clk && !sr_clk);
            if (cap_edge) begin
                cap_word = {cap_word[22:0], sr_data};
                cap_n++;
            end
            if (cap_edge && (sr_data != prev_data)) edge_err++;
            bz = (bus_addr == CSR_ACCESS) ? bus_rdata[0] : (busy_cnt != 0);
            if (bz) busy_cnt++;
            if (sr_store) begin
                frames++;
                last_word = cap_word;
                last_n = cap_n;
                last_len = busy_cnt;
                last_interval = int'(cyc - last_store_cyc);
                last_store_cyc = cyc;
                cap_word = '0;
                cap_n = 0;
                busy_cnt = 0;
            end
            if (idle_watch && (sr_clk || sr_data || sr_store)) idle_err++;
        end
        prev_clk = sr_clk;
        prev_data = sr_data;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = CSR_ACCESS; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        @(posedge clk); #1;
        bus_addr = CSR_ACCESS;
    endtask

    task automatic wait_frames(input int target, input int max_cyc);
        for (int i = 0; i < max_cyc && frames < target; i++) @(posedge clk);
    endtask

    function automatic int fls3(input logic [2:0] g);
        if (g[2]) return 3;
        if (g[1]) return 2;
        if (g[0]) return 1;
        return 0;
    endfunction

    function automatic logic [23:0] exp_merge(input logic [23:0] d,
        input logic [1:0] mo, input logic [1:0] p1, input logic [1:0] p2);
        logic [23:0] w;
        w = d;
        for (int k = 0; k < 2; k++) begin
            if (mo[k]) w[k]     = modem_stat[k];
            if (p1[k]) w[2 + k] = phy1_stat[k];
            if (p2[k]) w[5 + k] = phy2_stat[k];
        end
        return w;
    endfunction

    // one software-triggered frame and its checks
    task automatic run_frame(input logic [2:0] g, input bit fall, input logic [23:0] d,
                             input logic [1:0] mo, input logic [1:0] p1,
                             input logic [1:0] p2, input string req);
        int f0;
        int n;
        logic [23:0] exp_w;
        logic [23:0] mask;
        bus_write(CSR_CTRL1, {15'b0, p2, 12'b0, g});
        bus_write(CSR_DATA0, {8'b0, d});
        exp_fall = fall;
        f0 = frames;
        n = 8 * fls3(g);
        mask = (n == 24) ? 24'hFF_FFFF : ((24'd1 << n) - 24'd1);
        exp_w = exp_merge(d, mo, p1, p2) & mask;
        bus_write(CSR_CTRL0, {1'b1, 2'b0, p1, fall, mo, 24'b0});
        if (n == 0) begin
            repeat (150) @(posedge clk);
            check(frames == f0, "R4", "frame with no group", frames - f0, 0);
        end else begin
            wait_frames(f0 + 1, 300);
            repeat (20) @(posedge clk);
            check(frames == f0 + 1, "R3", "frame count", frames - f0, 1);
            check(last_n == n, "R4", "bits per frame", last_n, n);
            check(last_word == exp_w, req, "shifted word", last_word, exp_w);
            check(last_len == n * BIT_CYC + 1, "R8", "busy cycles", last_len, n * BIT_CYC + 1);
        end
    endtask

    initial begin
        logic [31:0] rd;
        int f0;
        int per;
        idle_watch = 1;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (40) @(posedge clk);

        // R1: reset values and quiet pins
        bus_read(CSR_CTRL0, rd);  check(rd == 32'h8000_0000, "R1", "ctrl0 reset", rd, 32'h8000_0000);
        bus_read(CSR_CTRL1, rd);  check(rd == 0, "R1", "ctrl1 reset", rd, 0);
        bus_read(CSR_DATA0, rd);  check(rd == 0, "R1", "data0 reset", rd, 0);
        bus_read(CSR_DATA1, rd);  check(rd == 0, "R1", "data1 reset", rd, 0);
        bus_read(CSR_ACCESS, rd); check(rd == 0, "R1", "access reset", rd, 0);
        check(idle_err == 0, "R1", "pin activity after reset", idle_err, 0);
        check(frames == 0, "R1", "frames after reset", frames, 0);
        idle_watch = 0;

        // R2: read back at each offset
        bus_write(CSR_DATA0, 32'hDEAD_BEEF);  bus_read(CSR_DATA0, rd);
        check(rd == 32'hDEAD_BEEF, "R2", "data0 readback", rd, 32'hDEAD_BEEF);
        bus_write(CSR_DATA1, 32'h1234_5678);  bus_read(CSR_DATA1, rd);
        check(rd == 32'h1234_5678, "R2", "data1 readback", rd, 32'h1234_5678);
        bus_write(CSR_CTRL1, 32'h0181_8001);  bus_read(CSR_CTRL1, rd);
        check(rd == 32'h0181_8001, "R2", "ctrl1 readback", rd, 32'h0181_8001);
        bus_write(CSR_ACCESS, 32'hFFFF_FFFF); bus_read(CSR_ACCESS, rd);
        check(rd == 32'hFFFF_FFFE, "R2", "access readback busy bit", rd, 32'hFFFF_FFFE);
        bus_write(CSR_ACCESS, 32'h0);
        f0 = frames;
        bus_write(CSR_CTRL0, 32'h0400_0000);  bus_read(CSR_CTRL0, rd);
        check(rd == 32'h0400_0000, "R2", "ctrl0 readback", rd, 32'h0400_0000);
        repeat (150) @(posedge clk);
        check(frames == f0, "R3", "write with mode bit clear starts no frame", frames - f0, 0);

        // R4 R5 R7 R8: every group set in both edge modes
        for (int g = 0; g < 8; g++) begin
            for (int e = 0; e < 2; e++) begin
                run_frame(3'(g), e[0], 24'hC35A69 ^ {3'(g), 20'h0, e[0]} ^ (24'h111111 * g),
                          2'b00, 2'b00, 2'b00, "R5");
            end
        end

        // R6: all override enable combinations with varying status
        for (int c = 0; c < 64; c++) begin
            modem_stat = 2'(c >> 1);
            phy1_stat  = 2'(c >> 3) ^ 2'b01;
            phy2_stat  = {c[0], c[5]};
            run_frame(3'b001, c[2], 24'(c * 37) ^ 24'h0000A5,
                      2'(c), 2'(c >> 2), 2'(c >> 4), "R6");
        end

        // R11: capture at frame start, later changes ignored
        modem_stat = 2'b11;
        bus_write(CSR_CTRL1, 32'h0000_0004);
        bus_write(CSR_DATA0, 32'h00A5_C3F0);
        exp_fall = 0;
        f0 = frames;
        bus_write(CSR_CTRL0, 32'h8300_0000);
        repeat (20) @(posedge clk);
        bus_write(CSR_DATA0, 32'h0000_0000);
        modem_stat = 2'b00;
        wait_frames(f0 + 1, 300);
        check(last_word == 24'hA5C3F3, "R11", "word captured at start", last_word, 24'hA5C3F3);

        // R9: request during a frame runs one more frame right after store
        bus_write(CSR_CTRL1, 32'h0000_0001);
        bus_write(CSR_DATA0, 32'h0000_0096);
        exp_fall = 1;
        f0 = frames;
        bus_write(CSR_CTRL0, 32'h8400_0000);
        repeat (10) @(posedge clk);
        bus_write(CSR_DATA0, 32'h0000_0069);
        bus_write(CSR_CTRL0, 32'h8400_0000);
        wait_frames(f0 + 2, 400);
        check(frames == f0 + 2, "R9", "pending frame ran", frames - f0, 2);
        check(last_interval == 8 * BIT_CYC + 1, "R9", "back-to-back store spacing",
              last_interval, 8 * BIT_CYC + 1);
        check(last_word == 24'h69, "R9", "pending frame word", last_word, 24'h69);
        repeat (200) @(posedge clk);
        check(frames == f0 + 2, "R9", "no extra frame", frames - f0, 2);

        // R10: timed refresh at each rate
        exp_fall = 0;
        bus_write(CSR_CTRL0, 32'h0000_0000);
        for (int r = 0; r < 4; r++) begin
            per = CLK_HZ / ((r == 0) ? 2 : (r == 1) ? 4 : (r == 2) ? 8 : 10);
            bus_write(CSR_CTRL1, 32'h8000_0001 | (32'(r) << 23));
            f0 = frames;
            wait_frames(f0 + 3, 4 * per);
            check(frames >= f0 + 3, "R10", "timed frames occur", frames - f0, 3);
            check(last_interval == per, "R10", "refresh period", last_interval, per);
        end
        bus_write(CSR_CTRL1, 32'h0180_0001);
        repeat (5) @(posedge clk);
        f0 = frames;
        repeat (1200) @(posedge clk);
        check(frames == f0, "R10", "no timed frames without bus source", frames - f0, 0);

        check(edge_err == 0, "R7", "data changed on sampling edge", edge_err, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog for a hung run
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL WDOG run incomplete: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule